// File: doc/BRIEF.md
# Paced Parallel Word Output Engine

This block streams words from a local first-in first-out store onto a parallel output bus. Three pacing schemes are available. In the first, an internal pacer releases one word per tick and marks it with a one-cycle strobe on the request line. In the second, a four-phase request/acknowledge exchange with the receiving device sets the rate. In the third, a burst scheme, the pacer sets the rate and the receiver holds acknowledge high to accept words or pulls it low to pause. The pacer tick comes from a fast divider, a divider at half that rate, or an externally supplied timer pulse.

The start of a run can be gated by a trigger input, by a requirement that the store hold more words than a programmable almost-empty threshold, or by both. A replay mode sends the stored words as a repeating pattern without consuming them. Optionally, the replay halts for good when the trigger is released. A sticky flag records every attempt to send while the store has nothing to give. The bus keeps its last value whenever no new word is sent.

Top module: `pat_out_engine`

## Requirements
- R1: After reset, doutReq, doutData, underrun and running are all 0.
- R2: With clkMode 0 (pacer), each pacer tick during a run sends the next stored word in write order. doutData and doutReq update together one cycle after the tick, and doutReq is high only in cycles that present a newly sent word.
- R3: pacerSel selects the tick source. Value 0 gives a tick every FAST_DIV cycles, value 1 every 2*FAST_DIV cycles, and values 2 and 3 give one tick in each cycle that timerTick is high.
- R4: With clkMode 1 (handshake), a word is presented and doutReq rises only after a cycle in which ack was low and doutReq was low. doutReq falls in the cycle after ack is sampled high.
- R5: With clkMode 2 (burst), a word is sent on a pacer tick only while ack is high. While ack is low, no word and no strobe appear.
- R6: startMode selects the start condition. Value 0 starts at once. Value 1 waits for trig high. Value 2 waits until the stored word count exceeds aeThresh. Value 3 waits for both. Until the condition holds, running stays 0 and no word is sent.
- R7: With patMode set, the loaded words are sent in order from the oldest and wrap back to the oldest after the newest. No word is consumed, so a run can send more words than were loaded.
- R8: With patMode and stopOnTrigRel set, trig going low during a run stops the run one cycle later. After that, no word is sent and running stays 0 until enable is dropped, even if trig returns high.
- R9: A send attempt while nothing is available sets underrun, which stays set until underrunClr. During such an attempt doutData holds its last value.
- R10: Dropping enable returns the block to idle, and doutReq and running are 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Arms the engine; low returns to idle |
| clkMode | input | 2 | 0 pacer, 1 handshake, 2 burst |
| pacerSel | input | 2 | 0 fast divider, 1 half-rate divider, 2/3 timerTick |
| timerTick | input | 1 | External timer pulse used as tick source |
| startMode | input | 2 | bit0 wait for trig, bit1 wait for count above threshold |
| aeThresh | input | clog2(DEPTH)+1 | Almost-empty threshold in words |
| patMode | input | 1 | Replay stored words cyclically |
| stopOnTrigRel | input | 1 | In replay, halt when trig falls |
| trig | input | 1 | Start / stop trigger |
| wrEn | input | 1 | Write a word into the store |
| wrData | input | DATA_W | Word to store |
| fifoClr | input | 1 | Empty the store and restart replay position |
| underrunClr | input | 1 | Clear the sticky underrun flag |
| ack | input | 1 | Acknowledge from the receiving device |
| doutData | output | DATA_W | Parallel output bus |
| doutReq | output | 1 | Strobe (pacer/burst) or request level (handshake) |
| underrun | output | 1 | Sticky send-while-empty flag |
| running | output | 1 | Run in progress |

## Verification
The main function is tried with a pacer run at full rate, where the word order and a strobe on every cycle show that nothing is skipped, and with a half-rate run, where the two-cycle spacing separates the divider choices. A handshake run with an automatic responder and a burst run with acknowledge held high show that the same word order survives the two acknowledge-driven schemes. A replay run that collects more words than were loaded tells wrapping replay apart from draining. Directed cases then cover each start gate, a burst pause, trigger-release halting, timer-pulse ticks, underrun hold and clear, and dropping enable.

// File: rtl/patout_pkg.sv
package patout_pkg;

  localparam logic [1:0] CM_PACER  = 2'd0;
  localparam logic [1:0] CM_HSHAKE = 2'd1;
  localparam logic [1:0] CM_BURST  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_HALT  = 2'd3
  } engState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic send;    // present next word on the bus
    logic starve;  // send attempted with nothing available
    logic rewind;  // restart replay position
  } dpStrobe_t;

endpackage

// File: rtl/patout_pacer.sv
module patout_pacer #(
  parameter int FAST_DIV = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic [1:0] pacerSel,
  input  logic       timerTick,
  output logic       tick
);
  localparam int SLOW_DIV = 2 * FAST_DIV;
  localparam int CNT_W    = $clog2(SLOW_DIV + 1);

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divLim;
  logic             divWrap;

  assign divLim  = (pacerSel == 2'd1) ? CNT_W'(SLOW_DIV) : CNT_W'(FAST_DIV);
  assign divWrap = (divCnt >= divLim - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      divCnt <= '0;
    end else if (divWrap) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + CNT_W'(1);
    end
  end

  assign tick = run && (pacerSel[1] ? timerTick : divWrap);

endmodule

// File: rtl/patout_dpath.sv
module patout_dpath
  import patout_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       fifoClr,
  input  logic                       underrunClr,
  input  logic                       patMode,
  input  dpStrobe_t                  strobe,
  output logic [DATA_W-1:0]          doutData,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       underrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;
  logic [AW-1:0]     patIdx;
  logic [AW-1:0]     rdAddr;
  logic [CW-1:0]     addrSum;
  logic              push;
  logic              pop;
  logic              patLast;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign push    = wrEn && (count != CW'(DEPTH)) && !fifoClr;
  assign pop     = strobe.send && !patMode;
  assign empty   = (count == '0);
  assign patLast = ({1'b0, patIdx} == count - CW'(1));

  assign addrSum = {1'b0, rdPtr} + {1'b0, patIdx};
  always_comb begin
    if (!patMode) begin
      rdAddr = rdPtr;
    end else if (addrSum >= CW'(DEPTH)) begin
      rdAddr = AW'(addrSum - CW'(DEPTH));
    end else begin
      rdAddr = AW'(addrSum);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || fifoClr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || fifoClr || strobe.rewind) begin
      patIdx <= '0;
    end else if (strobe.send && patMode) begin
      patIdx <= patLast ? '0 : patIdx + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doutData <= '0;
    end else if (strobe.send) begin
      doutData <= mem[rdAddr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      underrun <= 1'b0;
    end else if (strobe.starve) begin
      underrun <= 1'b1;
    end else if (underrunClr) begin
      underrun <= 1'b0;
    end
  end

  // R9: the flag persists until cleared
  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !underrunClr) |=> underrun);

  // R7: replay does not consume stored words
  assert_replay_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (patMode && strobe.send && !wrEn && !fifoClr) |=> (count == $past(count)));

  // R9: a starved attempt leaves the bus untouched
  assert_starve_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.starve && !strobe.send) |=> $stable(doutData));

endmodule

// File: rtl/patout_ctrl.sv
module patout_ctrl
  import patout_pkg::*;
#(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [1:0]    clkMode,
  input  logic [1:0]    startMode,
  input  logic          patMode,
  input  logic          stopOnTrigRel,
  input  logic          trig,
  input  logic          ack,
  input  logic          tick,
  input  logic          empty,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] aeThresh,
  output dpStrobe_t     strobe,
  output logic          doutReq,
  output logic          running
);
  engState_e state;
  logic      reqQ;
  logic      startOk;
  logic      haltNow;
  logic      sendTry;

  assign startOk = (!startMode[0] || trig) && (!startMode[1] || (count > aeThresh));
  assign haltNow = patMode && stopOnTrigRel && !trig;

  always_comb begin
    unique case (clkMode)
      CM_PACER:  sendTry = tick;
      CM_BURST:  sendTry = tick && ack;
      CM_HSHAKE: sendTry = !reqQ && !ack;
      default:   sendTry = 1'b0;
    endcase
  end

  always_comb begin
    strobe        = '0;
    strobe.rewind = (state == ST_IDLE);
    if (state == ST_RUN && enable && !haltNow) begin
      strobe.send   = sendTry && !empty;
      strobe.starve = sendTry && empty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      state <= ST_IDLE;
      reqQ  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          state <= ST_ARMED;
          reqQ  <= 1'b0;
        end
        ST_ARMED: begin
          if (startOk) state <= ST_RUN;
          reqQ <= 1'b0;
        end
        ST_RUN: begin
          if (haltNow) begin
            state <= ST_HALT;
            reqQ  <= 1'b0;
          end else if (clkMode == CM_HSHAKE) begin
            if (strobe.send)      reqQ <= 1'b1;
            else if (reqQ && ack) reqQ <= 1'b0;
          end else begin
            reqQ <= strobe.send;
          end
        end
        default: begin
          state <= ST_HALT;
          reqQ  <= 1'b0;
        end
      endcase
    end
  end

  assign doutReq = reqQ;
  assign running = (state == ST_RUN);

  // R4: request only rises after acknowledge was seen low
  assert_hs_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clkMode == CM_HSHAKE && $past(clkMode) == CM_HSHAKE && $rose(reqQ)) |-> !$past(ack));

  // R4: request drops once acknowledge is sampled
  assert_hs_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && clkMode == CM_HSHAKE && reqQ && ack) |=> !reqQ);

  // R10: dropping enable clears the request
  assert_idle_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!reqQ && !running));

  // R8: a halted run never resumes while enabled
  assert_halt_stays_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && enable) |=> (state == ST_HALT && !reqQ));

endmodule

// File: rtl/pat_out_engine.sv
module pat_out_engine
  import patout_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 256,
  parameter int FAST_DIV = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic [1:0]             clkMode,
  input  logic [1:0]             pacerSel,
  input  logic                   timerTick,
  input  logic [1:0]             startMode,
  input  logic [$clog2(DEPTH):0] aeThresh,
  input  logic                   patMode,
  input  logic                   stopOnTrigRel,
  input  logic                   trig,
  input  logic                   wrEn,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   fifoClr,
  input  logic                   underrunClr,
  input  logic                   ack,
  output logic [DATA_W-1:0]      doutData,
  output logic                   doutReq,
  output logic                   underrun,
  output logic                   running
);
  localparam int CW = $clog2(DEPTH) + 1;

  dpStrobe_t     strobe;
  logic          tick;
  logic          empty;
  logic [CW-1:0] count;

  patout_pacer #(.FAST_DIV(FAST_DIV)) u_pacer (
    .clk      (clk),
    .rstN     (rstN),
    .run      (running),
    .pacerSel (pacerSel),
    .timerTick(timerTick),
    .tick     (tick)
  );

  patout_ctrl #(.CW(CW)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .clkMode      (clkMode),
    .startMode    (startMode),
    .patMode      (patMode),
    .stopOnTrigRel(stopOnTrigRel),
    .trig         (trig),
    .ack          (ack),
    .tick         (tick),
    .empty        (empty),
    .count        (count),
    .aeThresh     (aeThresh),
    .strobe       (strobe),
    .doutReq      (doutReq),
    .running      (running)
  );

  patout_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .fifoClr    (fifoClr),
    .underrunClr(underrunClr),
    .patMode    (patMode),
    .strobe     (strobe),
    .doutData   (doutData),
    .count      (count),
    .empty      (empty),
    .underrun   (underrun)
  );

endmodule

// File: tb/pat_out_engine_tb.sv
module pat_out_engine_tb;

  typedef struct packed {
    logic [1:0] cm;
    logic [1:0] ps;
    logic       pm;
    logic [7:0] nLoad;
    logic [7:0] nExp;
    logic [7:0] seed;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 2'd0, 1'b0, 8'd3, 8'd3, 8'd1},
    '{2'd0, 2'd1, 1'b0, 8'd4, 8'd4, 8'd2},
    '{2'd1, 2'd0, 1'b0, 8'd3, 8'd3, 8'd3},
    '{2'd2, 2'd0, 1'b0, 8'd3, 8'd3, 8'd4},
    '{2'd0, 2'd0, 1'b1, 8'd3, 8'd8, 8'd5}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  clkMode = 2'd0;
  logic [1:0]  pacerSel = 2'd0;
  logic        timerTick = 1'b0;
  logic [1:0]  startMode = 2'd0;
  logic [8:0]  aeThresh = 9'd0;
  logic        patMode = 1'b0;
  logic        stopOnTrigRel = 1'b0;
  logic        trig = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = 32'd0;
  logic        fifoClr = 1'b0;
  logic        underrunClr = 1'b0;
  logic        manualAck = 1'b0;
  logic        respAck = 1'b0;
  logic        hsAuto = 1'b0;
  logic        ack;
  logic [31:0] doutData;
  logic        doutReq;
  logic        underrun;
  logic        running;

  int checks = 0;
  int errors = 0;
  logic [31:0] cap [32];
  int          capCyc [32];
  int          nCap;

  assign ack = hsAuto ? respAck : manualAck;

  always #2.5 clk = ~clk;

  pat_out_engine u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .clkMode(clkMode),
    .pacerSel(pacerSel), .timerTick(timerTick), .startMode(startMode),
    .aeThresh(aeThresh), .patMode(patMode), .stopOnTrigRel(stopOnTrigRel),
    .trig(trig), .wrEn(wrEn), .wrData(wrData), .fifoClr(fifoClr),
    .underrunClr(underrunClr), .ack(ack), .doutData(doutData),
    .doutReq(doutReq), .underrun(underrun), .running(running)
  );

  // automatic four-phase responder for handshake runs
  always @(negedge clk) begin
    if (!hsAuto)                  respAck <= 1'b0;
    else if (doutReq && !respAck) respAck <= 1'b1;
    else if (!doutReq && respAck) respAck <= 1'b0;
  end

  function automatic logic [31:0] mk(input int seed, input int k);
    return 32'hA000_0000 | (32'(seed) << 8) | 32'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int seed, input int from, input int n);
    for (int k = 0; k < n; k++) begin
      wrEn = 1'b1;
      wrData = mk(seed, from + k);
      @(negedge clk);
    end
    wrEn = 1'b0;
  endtask

  task automatic load(input int seed, input int n);
    fifoClr = 1'b1;
    @(negedge clk);
    fifoClr = 1'b0;
    push(seed, 0, n);
  endtask

  task automatic collect(input int cm, input int nExp, input int maxCyc);
    logic prevReq;
    prevReq = 1'b0;
    nCap = 0;
    for (int c = 0; c < maxCyc && nCap < nExp; c++) begin
      @(negedge clk);
      if (doutReq && (cm != 1 || !prevReq)) begin
        cap[nCap] = doutData;
        capCyc[nCap] = c;
        nCap++;
      end
      prevReq = doutReq;
    end
  endtask

  task automatic quiesce();
    enable = 1'b0;
    hsAuto = 1'b0;
    manualAck = 1'b0;
    trig = 1'b0;
    patMode = 1'b0;
    stopOnTrigRel = 1'b0;
    startMode = 2'd0;
    pacerSel = 2'd0;
    clkMode = 2'd0;
    underrunClr = 1'b1;
    @(negedge clk);
    underrunClr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    bit seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(doutReq == 1'b0, "R1 req", 32'(doutReq), 32'd0);
    chk(doutData == 32'd0, "R1 data", doutData, 32'd0);
    chk(underrun == 1'b0, "R1 underrun", 32'(underrun), 32'd0);
    chk(running == 1'b0, "R1 running", 32'(running), 32'd0);

    // table-driven runs
    for (int v = 0; v < NVEC; v++) begin
      clkMode = VEC[v].cm;
      pacerSel = VEC[v].ps;
      patMode = VEC[v].pm;
      hsAuto = (VEC[v].cm == 2'd1);
      manualAck = (VEC[v].cm == 2'd2);
      load(int'(VEC[v].seed), int'(VEC[v].nLoad));
      enable = 1'b1;
      collect(int'(VEC[v].cm), int'(VEC[v].nExp), 200);
      chk(nCap == int'(VEC[v].nExp), "R2 R4 R5 R7 word count", 32'(nCap), 32'(VEC[v].nExp));
      for (int i = 0; i < nCap; i++) begin
        logic [31:0] e;
        e = mk(int'(VEC[v].seed), VEC[v].pm ? (i % int'(VEC[v].nLoad)) : i);
        chk(cap[i] == e, "R2 R4 R5 R7 word value", cap[i], e);
        if (i > 0 && VEC[v].cm == 2'd0) begin
          int gap;
          gap = (VEC[v].ps == 2'd1) ? 2 : 1;
          chk(capCyc[i] - capCyc[i-1] == gap, "R3 pacer spacing", 32'(capCyc[i] - capCyc[i-1]), 32'(gap));
        end
      end
      repeat (5) @(negedge clk);
      if (VEC[v].pm) chk(underrun == 1'b0, "R7 replay never starves", 32'(underrun), 32'd0);
      else           chk(underrun == 1'b1, "R9 underrun after drain", 32'(underrun), 32'd1);
      quiesce();
    end

    // R9 hold and clear
    load(7, 2);
    enable = 1'b1;
    collect(0, 2, 50);
    repeat (4) @(negedge clk);
    chk(doutData == mk(7, 1), "R9 bus holds last word", doutData, mk(7, 1));
    chk(underrun == 1'b1, "R9 sticky set", 32'(underrun), 32'd1);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(underrun == 1'b1, "R9 sticky without clear", 32'(underrun), 32'd1);
    underrunClr = 1'b1;
    @(negedge clk);
    underrunClr = 1'b0;
    chk(underrun == 1'b0, "R9 cleared", 32'(underrun), 32'd0);
    quiesce();

    // R6 wait for trigger
    startMode = 2'd1;
    load(8, 2);
    enable = 1'b1;
    seen = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (doutReq || running) seen = 1'b1;
    end
    chk(!seen, "R6 trigger gate holds", 32'(seen), 32'd0);
    trig = 1'b1;
    collect(0, 2, 50);
    chk(nCap == 2 && cap[0] == mk(8, 0), "R6 starts on trigger", cap[0], mk(8, 0));
    quiesce();

    // R6 wait for count above threshold
    startMode = 2'd2;
    aeThresh = 9'd3;
    load(9, 2);
    enable = 1'b1;
    repeat (6) @(negedge clk);
    chk(running == 1'b0, "R6 threshold gate holds", 32'(running), 32'd0);
    push(9, 2, 1);
    repeat (3) @(negedge clk);
    chk(running == 1'b0, "R6 count equal to threshold", 32'(running), 32'd0);
    push(9, 3, 1);
    collect(0, 4, 50);
    chk(nCap == 4 && cap[3] == mk(9, 3), "R6 starts above threshold", cap[3], mk(9, 3));
    quiesce();

    // R6 both conditions
    startMode = 2'd3;
    aeThresh = 9'd1;
    load(10, 3);
    enable = 1'b1;
    repeat (6) @(negedge clk);
    chk(running == 1'b0, "R6 both gate waits for trig", 32'(running), 32'd0);
    trig = 1'b1;
    collect(0, 3, 50);
    chk(nCap == 3 && cap[0] == mk(10, 0), "R6 both gate starts", cap[0], mk(10, 0));
    quiesce();

    // R5 burst pause
    clkMode = 2'd2;
    manualAck = 1'b0;
    load(11, 3);
    enable = 1'b1;
    seen = 1'b0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (doutReq) seen = 1'b1;
    end
    chk(!seen && running, "R5 ack low pauses burst", 32'(seen), 32'd0);
    manualAck = 1'b1;
    collect(2, 3, 50);
    chk(nCap == 3 && cap[2] == mk(11, 2), "R5 burst resumes", cap[2], mk(11, 2));
    quiesce();

    // R3 timer tick source
    pacerSel = 2'd2;
    load(12, 3);
    enable = 1'b1;
    seen = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (doutReq) seen = 1'b1;
    end
    chk(!seen, "R3 no tick without timer pulse", 32'(seen), 32'd0);
    timerTick = 1'b1;
    @(negedge clk);
    timerTick = 1'b0;
    chk(doutReq == 1'b1 && doutData == mk(12, 0), "R3 timer pulse sends", doutData, mk(12, 0));
    @(negedge clk);
    chk(doutReq == 1'b0, "R3 one word per pulse", 32'(doutReq), 32'd0);
    quiesce();

    // R8 stop on trigger release
    patMode = 1'b1;
    stopOnTrigRel = 1'b1;
    startMode = 2'd1;
    trig = 1'b1;
    load(13, 4);
    enable = 1'b1;
    collect(0, 3, 50);
    trig = 1'b0;
    @(negedge clk);
    held = doutData;
    chk(doutReq == 1'b0 && running == 1'b0, "R8 halts on release", 32'({doutReq, running}), 32'd0);
    seen = 1'b0;
    trig = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (doutReq || running || doutData != held) seen = 1'b1;
    end
    chk(!seen, "R8 stays halted", 32'(seen), 32'd0);

    // R10 enable drop during a replay run
    enable = 1'b0;
    @(negedge clk);
    stopOnTrigRel = 1'b0;
    startMode = 2'd0;
    enable = 1'b1;
    collect(0, 2, 50);
    chk(cap[0] == mk(13, 0), "R7 replay restarts at oldest", cap[0], mk(13, 0));
    enable = 1'b0;
    @(negedge clk);
    chk(doutReq == 1'b0 && running == 1'b0, "R10 idle after enable drop", 32'({doutReq, running}), 32'd0);
    quiesce();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule